// File: doc/BRIEF.md
# Debug Run-Control and Status Unit

This block sits between an external debugger and a processor core. Through a small word-indexed 32-bit register port the debugger can stop the core, start it again, set a handful of debug-mode controls, and read back a single status word. That word shows whether the core is stopped, whether a restart is still under way, what caused the last stop, and a few sticky event flags.

On the core side the unit takes a stop strobe carrying a 4-bit cause, a restart-complete strobe, a pulse for each retired instruction, and three exception strobes. The debugger works on two registers. A status/control word at word index 34 (byte offset 136) is readable and partly writable. A command word at word index 36 (byte offset 144) is write-only and each of its bits starts one action. The core stays stopped while `halted` is high. It should resume when it sees `restart_req` and report completion on `core_restart_done`.

Top module: `dbg_runctl`

## Requirements
- R1: After reset the status word reads 0x00000002: Restarted (bit 1) is 1, every other bit is 0, and the outputs `halted`, `restart_req`, `dbg_ack` and `irq_mask` are low.
- R2: Writing a command word with bit 0 set puts the unit in debug state one cycle later (status bit 0 and `halted` go to 1), with cause 0000 (debugger request) in status bits 5:2. The write does this only when status bit 14 (halting mode enable) is 1. When bit 14 is 0 the write is ignored.
- R3: A `core_halt_evt` strobe while the unit is running enters debug state and latches `core_halt_cause` into status bits 5:2. The cause codes are 0000 debugger request, 0001 hardware breakpoint, 0010 asynchronous watchpoint, 0011 software breakpoint, 0100 external halt, 0101 vector catch, 1000 unlock catch and 1010 synchronous watchpoint. Further core strobes and command halts while already halted leave the cause unchanged. The cause also holds after a restart, until the next entry.
- R4: A command write with bit 1 set while halted, and with bit 0 clear, clears Restarted (bit 1) and raises `restart_req`. When `core_restart_done` arrives, Halted drops, Restarted returns to 1 and `restart_req` drops. A restart command is ignored while running. A restart command is also not performed when bit 0 is set in the same write.
- R5: Status bit 25 (pipeline advance) is set by every `core_retire` pulse. Only a command write with bit 3 set clears it; a command with bit 2 set leaves it alone.
- R6: Status bits 8, 7 and 6 are sticky flags for undefined instruction, asynchronous abort and synchronous abort. Each is set only by its strobe while halted. The asynchronous abort flag is set only when status bit 19 (discard asynchronous aborts) is 1. A command write with bit 2 set clears all three.
- R7: When a sticky flag's set event and its clear command arrive in the same cycle, the flag ends up set.
- R8: Status bits 19, 15, 14, 13, 11 and 10 are read/write control bits. Bit 11 drives `irq_mask`, and `dbg_ack` is bit 10 OR Halted.
- R9: Writes to the status word do not change the read-only bits (0-9, 12, 16-18, 20-31). Reads of the command word (index 36), and of any index other than 34, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | IDX_W | Register word index (byte address / 4) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_idx`, combinational |
| core_halt_evt | input | 1 | Core entered debug state (strobe) |
| core_halt_cause | input | 4 | Cause code that goes with `core_halt_evt` |
| core_restart_done | input | 1 | Core has resumed normal execution (strobe) |
| core_retire | input | 1 | One or more instructions retired this cycle |
| core_undef_evt | input | 1 | Undefined-instruction exception |
| core_async_abort_evt | input | 1 | Asynchronous abort |
| core_sync_abort_evt | input | 1 | Synchronous data abort |
| halted | output | 1 | Core must stay in debug state |
| restart_req | output | 1 | Restart requested, waiting for the core |
| dbg_ack | output | 1 | Debug acknowledge |
| irq_mask | output | 1 | Interrupt mask control |

## Verification
The bench builds the unit with its default parameters. These are an 8-bit word index, status at index 34 and command at index 36. That index width lets the bench reach the neighbouring index 35 and confirm it reads as zero, next to the write-only command word. The width and the two index positions are parameters, but the bit layout inside the words is fixed by behaviour, so the defaults exercise every field the unit has. Same-cycle collisions are driven on purpose: a clear together with an event, halt together with restart, and a core strobe while already halted.

// File: rtl/dbg_runctl_pkg.sv
package dbg_runctl_pkg;

  localparam int WORD_W = 32;
  localparam int CAUSE_W = 4;

  // status word field positions (decoded by the debugger)
  localparam int ST_HALTED   = 0;
  localparam int ST_RESTART  = 1;
  localparam int ST_CAUSE_LO = 2;
  localparam int ST_SYNC_AB  = 6;
  localparam int ST_ASYNC_AB = 7;
  localparam int ST_UNDEF    = 8;
  localparam int ST_ACK_FRC  = 10;
  localparam int ST_IRQ_MASK = 11;
  localparam int ST_XFER_EN  = 13;
  localparam int ST_HALT_EN  = 14;
  localparam int ST_MON_EN   = 15;
  localparam int ST_DISCARD  = 19;
  localparam int ST_PIPEADV  = 25;

  // command word bit positions
  localparam int CMD_HALT     = 0;
  localparam int CMD_RESTART  = 1;
  localparam int CMD_CLR_EXC  = 2;
  localparam int CMD_CLR_PIPE = 3;

  localparam logic [CAUSE_W-1:0] CAUSE_DBG_REQ = 4'b0000;

  // sticky flag slots inside the flag bank
  localparam int FL_PIPE  = 0;
  localparam int FL_UNDEF = 1;
  localparam int FL_ASYNC = 2;
  localparam int FL_SYNC  = 3;
  localparam int NFLAG    = 4;

  localparam logic [WORD_W-1:0] RW_MASK =
      (WORD_W'(1) << ST_ACK_FRC) | (WORD_W'(1) << ST_IRQ_MASK) |
      (WORD_W'(1) << ST_XFER_EN) | (WORD_W'(1) << ST_HALT_EN)  |
      (WORD_W'(1) << ST_MON_EN)  | (WORD_W'(1) << ST_DISCARD);

  // merge a status write into the writable control bits
  function automatic logic [WORD_W-1:0] merge_ctrl(
      input logic [WORD_W-1:0] old_v, input logic [WORD_W-1:0] wr_v);
    return (old_v & ~RW_MASK) | (wr_v & RW_MASK);
  endfunction

  // assemble the status word from its sources
  function automatic logic [WORD_W-1:0] build_status(
      input logic [WORD_W-1:0] ctrl, input logic [NFLAG-1:0] fl,
      input logic [CAUSE_W-1:0] cause, input logic rst_done, input logic hlt);
    logic [WORD_W-1:0] s;
    s = ctrl & RW_MASK;
    s[ST_PIPEADV] = fl[FL_PIPE];
    s[ST_UNDEF]   = fl[FL_UNDEF];
    s[ST_ASYNC_AB] = fl[FL_ASYNC];
    s[ST_SYNC_AB] = fl[FL_SYNC];
    s[ST_CAUSE_LO +: CAUSE_W] = cause;
    s[ST_RESTART] = rst_done;
    s[ST_HALTED]  = hlt;
    return s;
  endfunction

endpackage

// File: rtl/dbg_run_fsm.sv
module dbg_run_fsm
  import dbg_runctl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               halt_en,
  input  logic               cmd_halt,
  input  logic               cmd_restart,
  input  logic               core_halt_evt,
  input  logic [CAUSE_W-1:0] core_halt_cause,
  input  logic               core_restart_done,
  output logic               halted_q,
  output logic               restarted_q,
  output logic               restart_pend_q,
  output logic [CAUSE_W-1:0] cause_q
);

  logic enter_dbg;
  logic start_restart;
  logic finish_restart;
  logic [CAUSE_W-1:0] entry_cause;

  assign enter_dbg      = !halted_q && (core_halt_evt || (cmd_halt && halt_en));
  assign entry_cause    = core_halt_evt ? core_halt_cause : CAUSE_DBG_REQ;
  assign start_restart  = halted_q && !restart_pend_q && cmd_restart && !cmd_halt;
  assign finish_restart = restart_pend_q && core_restart_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      halted_q       <= 1'b0;
      restarted_q    <= 1'b1;
      restart_pend_q <= 1'b0;
      cause_q        <= CAUSE_DBG_REQ;
    end else begin
      if (enter_dbg) begin
        halted_q <= 1'b1;
        cause_q  <= entry_cause;
      end else if (finish_restart) begin
        halted_q <= 1'b0;
      end
      if (start_restart) begin
        restarted_q    <= 1'b0;
        restart_pend_q <= 1'b1;
      end else if (finish_restart) begin
        restarted_q    <= 1'b1;
        restart_pend_q <= 1'b0;
      end
    end
  end

  AST_CAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (halted_q && $past(halted_q)) |-> $stable(cause_q)); // R3
  AST_RESTART_NEEDS_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(restarted_q) |-> halted_q); // R4
  AST_EXIT_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(halted_q) |-> $past(core_restart_done)); // R4
  AST_REQ_ONLY_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
    restart_pend_q |-> halted_q); // R4

endmodule

// File: rtl/dbg_sticky_bank.sv
module dbg_sticky_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_q
);

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)        flag_q[i] <= 1'b0;
      else if (set_i[i]) flag_q[i] <= 1'b1;
      else if (clr_i[i]) flag_q[i] <= 1'b0;
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      $past(set_i[i]) |-> flag_q[i]); // R7
    AST_FALL_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_q[i]) |-> $past(clr_i[i])); // R5
  end

endmodule

// File: rtl/dbg_runctl.sv
module dbg_runctl
  import dbg_runctl_pkg::*;
#(
  parameter int IDX_W      = 8,
  parameter int STATUS_IDX = 34,
  parameter int RUNCTL_IDX = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [IDX_W-1:0]  reg_idx,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  input  logic              core_halt_evt,
  input  logic [CAUSE_W-1:0] core_halt_cause,
  input  logic              core_restart_done,
  input  logic              core_retire,
  input  logic              core_undef_evt,
  input  logic              core_async_abort_evt,
  input  logic              core_sync_abort_evt,
  output logic              halted,
  output logic              restart_req,
  output logic              dbg_ack,
  output logic              irq_mask
);

  localparam logic [IDX_W-1:0] ST_SEL = IDX_W'(STATUS_IDX);
  localparam logic [IDX_W-1:0] RC_SEL = IDX_W'(RUNCTL_IDX);

  logic              wr_status;
  logic              wr_cmd;
  logic [WORD_W-1:0] ctrl_q;
  logic [NFLAG-1:0]  fl_set;
  logic [NFLAG-1:0]  fl_clr;
  logic [NFLAG-1:0]  fl_q;
  logic              restarted_q;
  logic [CAUSE_W-1:0] cause_q;
  logic [WORD_W-1:0] status_word;

  assign wr_status = reg_wr && (reg_idx == ST_SEL);
  assign wr_cmd    = reg_wr && (reg_idx == RC_SEL);

  always_ff @(posedge clk) begin
    if (!rst_n)         ctrl_q <= '0;
    else if (wr_status) ctrl_q <= merge_ctrl(ctrl_q, reg_wdata);
  end

  dbg_run_fsm u_fsm (
    .clk              (clk),
    .rst_n            (rst_n),
    .halt_en          (ctrl_q[ST_HALT_EN]),
    .cmd_halt         (wr_cmd && reg_wdata[CMD_HALT]),
    .cmd_restart      (wr_cmd && reg_wdata[CMD_RESTART]),
    .core_halt_evt    (core_halt_evt),
    .core_halt_cause  (core_halt_cause),
    .core_restart_done(core_restart_done),
    .halted_q         (halted),
    .restarted_q      (restarted_q),
    .restart_pend_q   (restart_req),
    .cause_q          (cause_q)
  );

  always_comb begin
    fl_set = '0;
    fl_set[FL_PIPE]  = core_retire;
    fl_set[FL_UNDEF] = halted && core_undef_evt;
    fl_set[FL_ASYNC] = halted && core_async_abort_evt && ctrl_q[ST_DISCARD];
    fl_set[FL_SYNC]  = halted && core_sync_abort_evt;
    fl_clr = '0;
    fl_clr[FL_PIPE]  = wr_cmd && reg_wdata[CMD_CLR_PIPE];
    fl_clr[FL_UNDEF] = wr_cmd && reg_wdata[CMD_CLR_EXC];
    fl_clr[FL_ASYNC] = wr_cmd && reg_wdata[CMD_CLR_EXC];
    fl_clr[FL_SYNC]  = wr_cmd && reg_wdata[CMD_CLR_EXC];
  end

  dbg_sticky_bank #(.N(NFLAG)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (fl_set),
    .clr_i (fl_clr),
    .flag_q(fl_q)
  );

  assign status_word = build_status(ctrl_q, fl_q, cause_q, restarted_q, halted);
  assign reg_rdata   = (reg_idx == ST_SEL) ? status_word : '0;
  assign dbg_ack     = ctrl_q[ST_ACK_FRC] | halted;
  assign irq_mask    = ctrl_q[ST_IRQ_MASK];

  AST_CMD_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_idx == RC_SEL) |-> (reg_rdata == '0)); // R9
  AST_ASYNC_NEEDS_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_q[FL_ASYNC]) |-> $past(ctrl_q[ST_DISCARD])); // R6
  AST_EXC_ONLY_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_q[FL_UNDEF]) |-> $past(halted)); // R6
  AST_HALT_NEEDS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halted) |-> ($past(core_halt_evt) || $past(ctrl_q[ST_HALT_EN]))); // R2

endmodule

// File: tb/dbg_runctl_test.sv
module dbg_runctl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_idx = 8'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        core_halt_evt = 1'b0;
  logic [3:0]  core_halt_cause = 4'd0;
  logic        core_restart_done = 1'b0;
  logic        core_retire = 1'b0;
  logic        core_undef_evt = 1'b0;
  logic        core_async_abort_evt = 1'b0;
  logic        core_sync_abort_evt = 1'b0;
  logic        halted, restart_req, dbg_ack, irq_mask;

  int errors = 0;
  int checks = 0;

  localparam logic [7:0] ST = 8'd34;
  localparam logic [7:0] RC = 8'd36;
  // event mask bits for drive()
  localparam int E_HALT = 0, E_DONE = 1, E_RET = 2, E_UND = 3, E_ASY = 4, E_SYN = 5;

  always #2 clk = ~clk;

  dbg_runctl uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .core_halt_evt(core_halt_evt), .core_halt_cause(core_halt_cause),
    .core_restart_done(core_restart_done), .core_retire(core_retire),
    .core_undef_evt(core_undef_evt), .core_async_abort_evt(core_async_abort_evt),
    .core_sync_abort_evt(core_sync_abort_evt),
    .halted(halted), .restart_req(restart_req), .dbg_ack(dbg_ack), .irq_mask(irq_mask)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle of stimulus: optional write plus core events
  task automatic drive(input logic wr, input logic [7:0] idx, input logic [31:0] d,
                       input logic [5:0] ev, input logic [3:0] cause);
    @(negedge clk);
    reg_wr = wr; reg_idx = idx; reg_wdata = d;
    core_halt_evt = ev[E_HALT]; core_halt_cause = cause;
    core_restart_done = ev[E_DONE]; core_retire = ev[E_RET];
    core_undef_evt = ev[E_UND]; core_async_abort_evt = ev[E_ASY];
    core_sync_abort_evt = ev[E_SYN];
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0; core_halt_evt = 1'b0; core_restart_done = 1'b0;
    core_retire = 1'b0; core_undef_evt = 1'b0; core_async_abort_evt = 1'b0;
    core_sync_abort_evt = 1'b0;
  endtask

  task automatic wr(input logic [7:0] idx, input logic [31:0] d);
    drive(1'b1, idx, d, 6'd0, 4'd0);
  endtask

  task automatic ev(input logic [5:0] e, input logic [3:0] cause);
    drive(1'b0, ST, 32'd0, e, cause);
  endtask

  task automatic rd(input logic [7:0] idx, output logic [31:0] v);
    reg_idx = idx;
    #1 v = reg_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(ST, v);
    chk("R1 status", v, 32'h2);
    chk("R1 outputs", {28'd0, halted, restart_req, dbg_ack, irq_mask}, 32'd0);
  endtask

  task automatic t_halt_disabled;
    logic [31:0] v;
    wr(RC, 32'h1);
    rd(ST, v);
    chk("R2 halt ignored when disabled", v, 32'h2);
  endtask

  task automatic t_ctrl_bits;
    logic [31:0] v;
    wr(ST, 32'h0000_4000);
    rd(ST, v);
    chk("R8 halt enable readback", v, 32'h0000_4002);
    wr(ST, 32'hFFFF_FFFF);
    rd(ST, v);
    chk("R9 read-only bits ignore write", v, 32'h0008_EC02);
    chk("R8 irq_mask/dbg_ack forced", {30'd0, irq_mask, dbg_ack}, 32'h3);
    chk("R9 halted unchanged by status write", {31'd0, halted}, 32'd0);
    wr(ST, 32'h0000_4000);
    rd(ST, v);
    chk("R8 controls cleared", {v[15:0], 14'd0, irq_mask, dbg_ack}, {16'h4002, 16'd0});
  endtask

  task automatic t_dbg_halt;
    logic [31:0] v;
    wr(RC, 32'h1);
    rd(ST, v);
    chk("R2 debugger halt, cause 0000", v[5:0], 32'h3);
    chk("R8 dbg_ack while halted", {31'd0, dbg_ack}, 32'd1);
  endtask

  task automatic t_both_bits;
    logic [31:0] v;
    wr(RC, 32'h3);
    rd(ST, v);
    chk("R4 halt+restart: no restart", {v[1:0], 29'd0, restart_req}, {2'b11, 30'd0});
  endtask

  task automatic restart_core(input string tag);
    logic [31:0] v;
    wr(RC, 32'h2);
    rd(ST, v);
    chk({tag, " restart pending"}, {v[1:0], 29'd0, restart_req}, {2'b01, 29'd0, 1'b1});
    ev(6'd1 << E_DONE, 4'd0);
    rd(ST, v);
    chk({tag, " restart done"}, {v[1:0], 29'd0, restart_req}, {2'b10, 30'd0});
  endtask

  task automatic t_restart;
    logic [31:0] v;
    restart_core("R4");
    wr(RC, 32'h2);
    rd(ST, v);
    chk("R4 restart ignored while running", {v[1:0], 29'd0, restart_req}, {2'b10, 30'd0});
  endtask

  task automatic t_core_halt;
    logic [31:0] v;
    ev(6'd1 << E_HALT, 4'b0011);
    rd(ST, v);
    chk("R3 core halt latches cause 0011", v[5:0], 32'h0F);
    ev(6'd1 << E_HALT, 4'b1010);
    rd(ST, v);
    chk("R3 core strobe while halted keeps cause", v[5:0], 32'h0F);
    wr(RC, 32'h1);
    rd(ST, v);
    chk("R3 halt command while halted keeps cause", v[5:0], 32'h0F);
  endtask

  task automatic t_sticky;
    logic [31:0] v;
    ev(6'd1 << E_UND, 4'd0);
    ev(6'd1 << E_ASY, 4'd0);
    rd(ST, v);
    chk("R6 undef set, async blocked without discard", v[8:6], 32'b100);
    wr(ST, 32'h0008_4000);
    ev(6'd1 << E_ASY, 4'd0);
    ev(6'd1 << E_SYN, 4'd0);
    rd(ST, v);
    chk("R6 all three sticky flags", v[8:6], 32'b111);
    wr(RC, 32'h4);
    rd(ST, v);
    chk("R6 clear exceptions", v[8:6], 32'd0);
    drive(1'b1, RC, 32'h4, 6'd1 << E_UND, 4'd0);
    rd(ST, v);
    chk("R7 undef wins over clear", v[8:6], 32'b100);
    wr(RC, 32'h4);
  endtask

  task automatic t_running;
    logic [31:0] v;
    restart_core("R4");
    ev(6'd1 << E_UND, 4'd0);
    rd(ST, v);
    chk("R6 undef ignored while running", v[8:6], 32'd0);
    chk("R3 cause holds after restart", v[5:2], 32'h3);
  endtask

  task automatic t_pipe;
    logic [31:0] v;
    rd(ST, v);
    chk("R5 pipeline advance clear", v[25], 32'd0);
    ev(6'd1 << E_RET, 4'd0);
    rd(ST, v);
    chk("R5 retire sets advance", v[25], 32'd1);
    wr(RC, 32'h4);
    rd(ST, v);
    chk("R5 exception clear leaves advance", v[25], 32'd1);
    wr(RC, 32'h8);
    rd(ST, v);
    chk("R5 advance clear", v[25], 32'd0);
    drive(1'b1, RC, 32'h8, 6'd1 << E_RET, 4'd0);
    rd(ST, v);
    chk("R7 retire wins over clear", v[25], 32'd1);
  endtask

  task automatic t_reads;
    logic [31:0] v;
    rd(RC, v);
    chk("R9 command word reads zero", v, 32'd0);
    rd(8'd35, v);
    chk("R9 other index reads zero", v, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_halt_disabled();
    t_ctrl_bits();
    t_dbg_halt();
    t_both_bits();
    t_restart();
    t_core_halt();
    t_sticky();
    t_running();
    t_pipe();
    t_reads();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule